// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the storage and steering half of a 32-bit processor that completes each instruction over several clock cycles. It holds the program counter, the instruction register, a latch for memory read data, two operand latches fed from a 32-entry register file, and a latch for the ALU result. One memory port serves both instruction fetch and data access. A separate control sequencer drives every select and write-enable input on each cycle. The memory sits outside the block and returns its read data on `mem_rdata`.

The block passes the opcode and function fields of the held instruction and the ALU zero flag back to the sequencer. It presents the memory address and write data to the memory. The PC can be loaded unconditionally, loaded only when the ALU result is zero (for compare-and-branch), or loaded with a jump target. The jump target keeps the top four PC bits and fills the rest from the instruction's 26-bit index field.

Top module: `mcd_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the PC to zero, so that `mem_addr` reads 0 with `addr_sel`=0 after reset.
- R2: `mem_addr` shows the PC when `addr_sel`=0 and the ALU output latch when `addr_sel`=1.
- R3: The instruction register takes `mem_rdata` at a clock edge only when `ir_wr`=1 and otherwise holds. `opcode` is bits 31:26 of the held instruction and `funct` is bits 5:0.
- R4: With `rf_wr`=1 the register file writes one entry at the clock edge. The entry number is instruction bits 15:11 when `dst_is_rd`=1 and bits 20:16 when it is 0. The data is the memory data latch when `wb_from_mem`=1 and the ALU output latch when it is 0. With `rf_wr`=0 no entry changes.
- R5: Register entry 0 always reads as zero, and a write aimed at it has no effect.
- R6: On every clock edge the memory data latch loads `mem_rdata`, operand latch A loads the entry named by instruction bits 25:21, operand latch B loads the entry named by bits 20:16, and the ALU output latch loads the live ALU result. `mem_wdata` is operand latch B.
- R7: The first ALU operand is latch A when `alu_a_reg`=1 and the PC when it is 0.
- R8: `alu_b_sel` picks the second ALU operand: 00 latch B, 01 the constant 4, 10 instruction bits 15:0 sign-extended, 11 that value shifted left by two.
- R9: `alu_op` 00 adds and 01 subtracts. 10 decodes `funct`: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 signed set-less-than giving 1 or 0. Any other funct code, and `alu_op` 11, add.
- R10: `alu_zero` is 1 exactly when the live ALU result is all zeros.
- R11: The PC loads at a clock edge when `pc_wr`=1, or when `pc_wr_cond`=1 and `alu_zero`=1. Otherwise it holds.
- R12: `pc_src` picks the value loaded into the PC: 00 the live ALU result, 01 the ALU output latch, 10 the concatenation of PC bits 31:28, instruction bits 25:0 and two zero bits, 11 the live ALU result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_wr | input | 1 | Unconditional PC load |
| pc_wr_cond | input | 1 | PC load qualified by the ALU zero flag |
| addr_sel | input | 1 | Memory address source: 0 PC, 1 ALU output latch |
| ir_wr | input | 1 | Instruction register load |
| rf_wr | input | 1 | Register file write enable |
| dst_is_rd | input | 1 | Write entry from bits 15:11 (1) or 20:16 (0) |
| wb_from_mem | input | 1 | Write data from memory data latch (1) or ALU output latch (0) |
| alu_a_reg | input | 1 | First ALU operand: 1 latch A, 0 PC |
| alu_b_sel | input | 2 | Second ALU operand select |
| alu_op | input | 2 | ALU operation class |
| pc_src | input | 2 | Next-PC source select |
| mem_rdata | input | 32 | Read data from the shared memory |
| opcode | output | 6 | Held instruction bits 31:26 |
| funct | output | 6 | Held instruction bits 5:0 |
| alu_zero | output | 1 | Live ALU result is zero |
| mem_addr | output | 32 | Shared memory address |
| mem_wdata | output | 32 | Memory write data (operand latch B) |

## Verification
The two functions that can meet in one cycle are the ALU's compare and the PC's conditional load. In the second cycle of a branch, the ALU subtracts the operand latches to produce the zero flag. In that same cycle the PC takes the target held in the ALU output latch, which was computed one cycle earlier from the PC and the shifted offset. The bench sets up branches where the compared registers are equal and where they differ. It checks the zero flag before the edge and the PC through `mem_addr` after it, so a taken branch must land on the old target and a not-taken branch must leave the PC alone. A fetch cycle that loads the instruction register and advances the PC on the same edge is also checked: the fetch address must be the PC from before that edge.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    localparam int XLEN     = 32;
    localparam int NREG     = 32;
    localparam int RIDX_W   = $clog2(NREG);
    localparam int IMM_W    = 16;
    localparam int JIDX_W   = 26;
    localparam int PC_KEEP  = XLEN - JIDX_W - 2;

    typedef enum logic [1:0] {
        BSEL_REG    = 2'b00,
        BSEL_FOUR   = 2'b01,
        BSEL_IMM    = 2'b10,
        BSEL_IMM_SH = 2'b11
    } bsel_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10,
        AOP_RSVD  = 2'b11
    } aluop_e;

    typedef enum logic [1:0] {
        PCS_ALU    = 2'b00,
        PCS_ALUOUT = 2'b01,
        PCS_JUMP   = 2'b10,
        PCS_RSVD   = 2'b11
    } pcsrc_e;

    typedef enum logic [2:0] {
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_OR,
        FN_SLT
    } alufn_e;

    localparam logic [5:0] FC_ADD = 6'b100000;
    localparam logic [5:0] FC_SUB = 6'b100010;
    localparam logic [5:0] FC_AND = 6'b100100;
    localparam logic [5:0] FC_OR  = 6'b100101;
    localparam logic [5:0] FC_SLT = 6'b101010;

    typedef struct packed {
        logic [5:0]        opcode;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } instr_t;

    function automatic logic [IMM_W-1:0] imm_field(input instr_t ins);
        return {ins.rd, ins.shamt, ins.funct};
    endfunction

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [JIDX_W-1:0] jidx_field(input instr_t ins);
        return {ins.rs, ins.rt, imm_field(ins)};
    endfunction

    function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] pc,
                                                    input instr_t ins);
        return {pc[XLEN-1 -: PC_KEEP], jidx_field(ins), 2'b00};
    endfunction

endpackage

// File: rtl/mcd_regfile.sv
module mcd_regfile
    import mcd_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int DEPTH = NREG,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra0,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd0,
    output logic [W-1:0]  rd1
);

    logic [W-1:0] entry [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (i == 0) begin : g_zero
            assign entry[i] = '0;
        end else begin : g_store
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (we && (wa == AW'(i))) begin
                    q <= wd;
                end
            end
            assign entry[i] = q;
        end
    end

    assign rd0 = entry[ra0];
    assign rd1 = entry[ra1];

endmodule

// File: rtl/mcd_alu_ctrl.sv
module mcd_alu_ctrl
    import mcd_pkg::*;
(
    input  logic [1:0] op_class,
    input  logic [5:0] fcode,
    output alufn_e     fn
);

    alufn_e from_fcode;

    always_comb begin
        case (fcode)
            FC_ADD:  from_fcode = FN_ADD;
            FC_SUB:  from_fcode = FN_SUB;
            FC_AND:  from_fcode = FN_AND;
            FC_OR:   from_fcode = FN_OR;
            FC_SLT:  from_fcode = FN_SLT;
            default: from_fcode = FN_ADD;
        endcase
    end

    always_comb begin
        case (aluop_e'(op_class))
            AOP_ADD:   fn = FN_ADD;
            AOP_SUB:   fn = FN_SUB;
            AOP_FUNCT: fn = from_fcode;
            default:   fn = FN_ADD;
        endcase
    end

endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
    import mcd_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alufn_e       fn,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_SLT:  y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mcd_datapath.sv
module mcd_datapath
    import mcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pc_wr,
    input  logic        pc_wr_cond,
    input  logic        addr_sel,
    input  logic        ir_wr,
    input  logic        rf_wr,
    input  logic        dst_is_rd,
    input  logic        wb_from_mem,
    input  logic        alu_a_reg,
    input  logic [1:0]  alu_b_sel,
    input  logic [1:0]  alu_op,
    input  logic [1:0]  pc_src,
    input  logic [31:0] mem_rdata,
    output logic [5:0]  opcode,
    output logic [5:0]  funct,
    output logic        alu_zero,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata
);

    instr_t            ir_q;
    logic [XLEN-1:0]   pc_q, mdr_q, a_q, b_q, aluout_q;
    logic [XLEN-1:0]   rf_rd0, rf_rd1;
    logic [XLEN-1:0]   wr_data, opa, opb, alu_y, pc_d, imm_ext;
    logic [RIDX_W-1:0] wr_idx;
    alufn_e            fn;
    logic              pc_en;

    assign imm_ext = sext_imm(imm_field(ir_q));
    assign wr_idx  = dst_is_rd ? ir_q.rd : ir_q.rt;
    assign wr_data = wb_from_mem ? mdr_q : aluout_q;
    assign opa     = alu_a_reg ? a_q : pc_q;

    always_comb begin
        case (bsel_e'(alu_b_sel))
            BSEL_REG:    opb = b_q;
            BSEL_FOUR:   opb = XLEN'(4);
            BSEL_IMM:    opb = imm_ext;
            default:     opb = {imm_ext[XLEN-3:0], 2'b00};
        endcase
    end

    always_comb begin
        case (pcsrc_e'(pc_src))
            PCS_ALUOUT: pc_d = aluout_q;
            PCS_JUMP:   pc_d = jump_target(pc_q, ir_q);
            default:    pc_d = alu_y;
        endcase
    end

    assign pc_en = pc_wr | (pc_wr_cond & alu_zero);

    mcd_regfile #(.W(XLEN), .DEPTH(NREG)) u_rf (
        .clk (clk),
        .we  (rf_wr),
        .wa  (wr_idx),
        .wd  (wr_data),
        .ra0 (ir_q.rs),
        .ra1 (ir_q.rt),
        .rd0 (rf_rd0),
        .rd1 (rf_rd1)
    );

    mcd_alu_ctrl u_actl (
        .op_class (alu_op),
        .fcode    (ir_q.funct),
        .fn       (fn)
    );

    mcd_alu #(.W(XLEN)) u_alu (
        .a    (opa),
        .b    (opb),
        .fn   (fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            ir_q     <= '0;
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
        end else begin
            if (pc_en) begin
                pc_q <= pc_d;
            end
            if (ir_wr) begin
                ir_q <= instr_t'(mem_rdata);
            end
            mdr_q    <= mem_rdata;
            a_q      <= rf_rd0;
            b_q      <= rf_rd1;
            aluout_q <= alu_y;
        end
    end

    assign opcode    = ir_q.opcode;
    assign funct     = ir_q.funct;
    assign mem_addr  = addr_sel ? aluout_q : pc_q;
    assign mem_wdata = b_q;

endmodule

// File: rtl/mcd_datapath_chk.sv
module mcd_datapath_chk
    import mcd_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            ir_wr,
    input logic            pc_wr,
    input logic            pc_wr_cond,
    input logic            alu_zero,
    input logic [1:0]      pc_src,
    input logic [31:0]     mem_rdata,
    input logic [XLEN-1:0] ir_q,
    input logic [XLEN-1:0] mdr_q,
    input logic [XLEN-1:0] pc_q,
    input logic [XLEN-1:0] aluout_q
);

    assert_ir_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ir_wr |=> $stable(ir_q));

    assert_ir_load_R3: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> ir_q == $past(mem_rdata));

    assert_mdr_load_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> mdr_q == $past(mem_rdata));

    assert_pc_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !(pc_wr_cond && alu_zero)) |=> $stable(pc_q));

    assert_pc_latched_R12: assert property (@(posedge clk) disable iff (rst)
        ((pc_wr || (pc_wr_cond && alu_zero)) && pc_src == 2'b01)
        |=> pc_q == $past(aluout_q));

    assert_pc_jump_R12: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'b10)
        |=> pc_q == {$past(pc_q[31:28]), $past(ir_q[25:0]), 2'b00});

endmodule

bind mcd_datapath mcd_datapath_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ir_wr      (ir_wr),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .alu_zero   (alu_zero),
    .pc_src     (pc_src),
    .mem_rdata  (mem_rdata),
    .ir_q       (ir_q),
    .mdr_q      (mdr_q),
    .pc_q       (pc_q),
    .aluout_q   (aluout_q)
);

// File: tb/tb_mcd_datapath.sv
module tb_mcd_datapath;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pc_wr = 0, pc_wr_cond = 0, addr_sel = 0, ir_wr = 0;
    logic        rf_wr = 0, dst_is_rd = 0, wb_from_mem = 0, alu_a_reg = 0;
    logic [1:0]  alu_b_sel = 0, alu_op = 0, pc_src = 0;
    logic [31:0] mem_rdata = 0;
    logic [5:0]  opcode, funct;
    logic        alu_zero;
    logic [31:0] mem_addr, mem_wdata;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] m_rf [32];
    logic [31:0] m_pc;
    logic [31:0] seed_val;

    mcd_datapath dut (
        .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .addr_sel(addr_sel), .ir_wr(ir_wr), .rf_wr(rf_wr),
        .dst_is_rd(dst_is_rd), .wb_from_mem(wb_from_mem),
        .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
        .pc_src(pc_src), .mem_rdata(mem_rdata), .opcode(opcode),
        .funct(funct), .alu_zero(alu_zero), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        pc_wr = 0; pc_wr_cond = 0; addr_sel = 0; ir_wr = 0; rf_wr = 0;
        dst_is_rd = 0; wb_from_mem = 0; alu_a_reg = 0;
        alu_b_sel = 0; alu_op = 0; pc_src = 0;
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] exp_alu(input logic [5:0] f, input logic [31:0] a,
                                            input logic [31:0] b);
        case (f)
            6'b100010: return a - b;
            6'b100100: return a & b;
            6'b100101: return a | b;
            6'b101010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default:   return a + b;
        endcase
    endfunction

    // loads IR (first edge), then lets A/B pick up the named entries (second edge)
    task automatic load_ir(input logic [31:0] w);
        mem_rdata = w; ir_wr = 1;
        tick();
        ir_wr = 0;
        tick();
    endtask

    task automatic wr_reg(input logic [4:0] r, input logic [31:0] v);
        load_ir({6'h0, 5'd0, r, 16'h0});
        mem_rdata = v;
        tick();
        rf_wr = 1; wb_from_mem = 1; dst_is_rd = 0;
        tick();
        idle();
        if (r != 0) m_rf[r] = v;
    endtask

    task automatic rd_check(input logic [4:0] rs, input logic [4:0] rt, input string req);
        load_ir({6'h0, rs, rt, 16'h0});
        chk({req, " B/mem_wdata (R6)"}, mem_wdata, m_rf[rt]);
        alu_a_reg = 1; alu_b_sel = 2'b10; alu_op = 2'b00;
        tick();
        addr_sel = 1;
        #1;
        chk({req, " A via ALU latch (R2 R7)"}, mem_addr, m_rf[rs]);
        idle();
    endtask

    task automatic alu_rr(input logic [5:0] f, input logic [4:0] rs, input logic [4:0] rt,
                          input logic [4:0] rd);
        logic [31:0] e;
        e = exp_alu(f, m_rf[rs], m_rf[rt]);
        load_ir({6'h0, rs, rt, rd, 5'h0, f});
        chk("R3 funct field", {26'h0, funct}, {26'h0, f});
        alu_a_reg = 1; alu_b_sel = 2'b00; alu_op = 2'b10;
        #1;
        chk("R10 zero flag on funct op", {31'h0, alu_zero}, {31'h0, (e == 0)});
        tick();
        rf_wr = 1; wb_from_mem = 0; dst_is_rd = 1;
        tick();
        idle();
        if (rd != 0) m_rf[rd] = e;
        rd_check(rd, rt, "R9 R4 funct result");
    endtask

    task automatic branch(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
        logic [31:0] tgt;
        load_ir({6'h04, rs, rt, imm});
        tgt = m_pc + {sx(imm)[29:0], 2'b00};
        alu_a_reg = 0; alu_b_sel = 2'b11; alu_op = 2'b00;
        tick();
        addr_sel = 1;
        #1;
        chk("R8 R7 shifted offset target", mem_addr, tgt);
        addr_sel = 0;
        alu_a_reg = 1; alu_b_sel = 2'b00; alu_op = 2'b01; pc_src = 2'b01; pc_wr_cond = 1;
        #1;
        chk("R10 compare zero", {31'h0, alu_zero}, {31'h0, (m_rf[rs] == m_rf[rt])});
        tick();
        idle();
        if (m_rf[rs] == m_rf[rt]) m_pc = tgt;
        #1;
        chk("R11 R12 conditional PC", mem_addr, m_pc);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        seed_val = $urandom(32'h5EED_0042);
        for (int i = 0; i < 32; i++) m_rf[i] = 32'h0;
        m_pc = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R1 PC after reset", mem_addr, 32'h0);
        chk("R6 B after reset", mem_wdata, 32'h0);

        // fill every register with random data and read back
        for (int r = 1; r < 32; r++) wr_reg(5'(r), $urandom());
        for (int r = 1; r < 32; r += 3) rd_check(5'(r), 5'(31 - r), "R4 R6 fill");

        // R5: writes to entry 0 are discarded
        wr_reg(5'd0, 32'hDEAD_BEEF);
        rd_check(5'd0, 5'd0, "R5 entry zero");

        // R4: rf_wr low leaves the entry alone
        load_ir({6'h0, 5'd0, 5'd7, 16'h0});
        mem_rdata = 32'h1234_5678;
        tick(); tick();
        rd_check(5'd7, 5'd7, "R4 no write when disabled");

        // R11: PC never moved during all of the above
        #1;
        chk("R11 PC held without enables", mem_addr, 32'h0);

        // directed funct ops, including rd=0 and an unlisted code
        wr_reg(5'd1, 32'h8000_0000);
        wr_reg(5'd2, 32'h0000_0001);
        alu_rr(6'b101010, 5'd1, 5'd2, 5'd3);
        alu_rr(6'b101010, 5'd2, 5'd1, 5'd4);
        alu_rr(6'b100010, 5'd2, 5'd2, 5'd5);
        alu_rr(6'b100000, 5'd1, 5'd2, 5'd0);
        alu_rr(6'b000000, 5'd1, 5'd2, 5'd6);

        // random funct ops
        for (int k = 0; k < 30; k++) begin
            logic [5:0] f;
            case ($urandom_range(4, 0))
                0: f = 6'b100000;
                1: f = 6'b100010;
                2: f = 6'b100100;
                3: f = 6'b100101;
                default: f = 6'b101010;
            endcase
            alu_rr(f, 5'($urandom_range(31, 0)), 5'($urandom_range(31, 0)),
                   5'($urandom_range(31, 1)));
        end

        // R9: alu_op 01 subtract, 11 add, regardless of funct
        wr_reg(5'd8, 32'd100);
        wr_reg(5'd9, 32'd30);
        load_ir({6'h0, 5'd8, 5'd9, 5'd0, 5'd0, 6'b100100});
        alu_a_reg = 1; alu_b_sel = 2'b00; alu_op = 2'b01;
        tick(); addr_sel = 1; #1;
        chk("R9 forced subtract", mem_addr, 32'd70);
        addr_sel = 0; alu_op = 2'b11;
        tick(); addr_sel = 1; #1;
        chk("R9 reserved op adds", mem_addr, 32'd130);
        idle();

        // R8: sign-extended immediate, negative and positive
        load_ir({6'h23, 5'd8, 5'd0, 16'hFFF0});
        alu_a_reg = 1; alu_b_sel = 2'b10; alu_op = 2'b00;
        tick(); addr_sel = 1; #1;
        chk("R8 negative immediate", mem_addr, 32'd84);
        idle();

        // fetch: IR load and PC+4 on the same edge
        for (int k = 0; k < 3; k++) begin
            logic [31:0] w;
            w = $urandom();
            #1;
            chk("R2 fetch address is PC", mem_addr, m_pc);
            mem_rdata = w; ir_wr = 1; alu_a_reg = 0; alu_b_sel = 2'b01;
            alu_op = 2'b00; pc_src = 2'b00; pc_wr = 1;
            tick();
            idle();
            m_pc = m_pc + 4;
            #1;
            chk("R12 R7 PC plus four", mem_addr, m_pc);
            chk("R3 opcode", {26'h0, opcode}, {26'h0, w[31:26]});
            chk("R3 funct", {26'h0, funct}, {26'h0, w[5:0]});
            mem_rdata = ~w;
            tick();
            chk("R3 IR held without ir_wr", {20'h0, opcode, funct},
                {20'h0, w[31:26], w[5:0]});
        end

        // branches: taken and not taken
        wr_reg(5'd10, 32'h55);
        wr_reg(5'd11, 32'h55);
        wr_reg(5'd12, 32'h56);
        branch(5'd10, 5'd11, 16'h0010);
        branch(5'd10, 5'd12, 16'h0020);
        branch(5'd11, 5'd10, 16'hFFFC);

        // live ALU result into PC, then jump keeps top bits
        wr_reg(5'd13, 32'hA000_0000);
        wr_reg(5'd14, 32'h0000_0100);
        load_ir({6'h0, 5'd13, 5'd14, 16'h0});
        alu_a_reg = 1; alu_b_sel = 2'b00; alu_op = 2'b00; pc_src = 2'b00; pc_wr = 1;
        tick(); idle();
        m_pc = 32'hA000_0100;
        #1;
        chk("R12 PC from live ALU", mem_addr, m_pc);
        load_ir({6'h02, 26'h2AB_CDEF});
        pc_src = 2'b10; pc_wr = 1;
        tick(); idle();
        m_pc = {m_pc[31:28], 26'h2AB_CDEF, 2'b00};
        #1;
        chk("R12 jump target", mem_addr, m_pc);

        // reset in mid-run
        rst = 1;
        tick();
        rst = 0;
        #1;
        chk("R1 PC cleared by reset", mem_addr, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule